// File: doc/BRIEF.md
# Condition Register Update Unit

This block keeps a 32-bit condition register, split into eight 4-bit fields, together with the three flag bits of the fixed-point exception register: summary overflow, overflow and carry. It applies the condition-register updates that an integer and floating-point pipeline produces. Instruction decode and arithmetic sit outside the block, so operands and control arrive directly on ports.

There are four kinds of field update. A compare writes any chosen field and can run signed or unsigned, on 32 or 64 bits. A record-form update writes field 0 from a signed test of a result against zero. A floating-point summary update copies four status bits into field 1. A single-bit write sets or clears one bit chosen by a flat index. A whole-register write port replaces the entire register. A carry-detect helper reports an unsigned 64-bit carry and can load it into the carry flag.

All updates are synchronous and take effect at the next rising clock edge. Reset is active-low and asynchronous.

Top module: `cr_update_unit`

## Requirements
- R1: While reset is low, `cr_rd` is 0 and `xer_rd` is 0.
- R2: Field k of the register occupies bits [31-4k:28-4k], so field 0 is the top nibble and field 7 is the bottom nibble. Inside a field, bit 3 (weight 8) is less-than, bit 2 (weight 4) is greater-than, bit 1 (weight 2) is equal and bit 0 (weight 1) is summary overflow.
- R3: A compare (`cmp_en`) writes the field selected by `cmp_sel`. Exactly one of less-than, greater-than or equal is set in that field, and the other two are cleared. The other fields keep their values.
- R4: The summary-overflow bit of a compared or record-updated field takes the exception-register summary-overflow value that was held before that clock edge.
- R5: `cmp_wide`=1 compares all 64 bits and `cmp_wide`=0 compares only bits [31:0]. `cmp_sgn`=1 compares as two's complement and `cmp_sgn`=0 compares as unsigned.
- R6: A record update (`rec_en`) writes field 0 from a signed comparison of `rec_val` against zero. The comparison covers 64 bits when `rec_wide`=1 and the low 32 bits when `rec_wide`=0.
- R7: A floating-point summary update (`fps_en`) loads field 1 as follows: less-than from `fps_fx`, greater-than from `fps_fex`, equal from `fps_vx` and summary overflow from `fps_ox`.
- R8: A single-bit write (`bit_en`) with index n writes `bit_val` into field n>>2 at in-field mask 0x8>>(n&3), which is register bit 31-n. All other bits are unchanged.
- R9: When several field-level updates land in the same cycle, compare overrides record, record overrides floating-point summary, and all three override a single-bit write wherever they overlap. Updates to different fields all apply together.
- R10: `cr_wr_en` loads `cr_wr_data` into the whole register, and every field-level update in that cycle is discarded.
- R11: In the 32-bit view of the exception register, summary overflow is bit 31 (0x80000000), overflow is bit 30 (0x40000000) and carry is bit 29 (0x20000000). `xer_wr_en` loads these three bits from `xer_wr_data`, and all other bits of `xer_rd` read as 0.
- R12: `ca_out` is 1 exactly when `ca_a` > ~`ca_b` as unsigned 64-bit values. `ca_load` writes `ca_out` into the carry flag and takes priority over `xer_wr_en` for that bit.
- R13: In a cycle with no enable asserted, both `cr_rd` and `xer_rd` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en | input | 1 | Compare update enable |
| cmp_sel | input | 3 | Target field of the compare |
| cmp_sgn | input | 1 | 1 = signed compare |
| cmp_wide | input | 1 | 1 = 64-bit compare, 0 = low 32 bits |
| cmp_a | input | 64 | Left operand |
| cmp_b | input | 64 | Right operand |
| rec_en | input | 1 | Record-form update of field 0 |
| rec_wide | input | 1 | Width of the record test |
| rec_val | input | 64 | Result tested against zero |
| fps_en | input | 1 | Floating-point summary update of field 1 |
| fps_fx | input | 1 | Exception summary bit |
| fps_fex | input | 1 | Enabled exception summary bit |
| fps_vx | input | 1 | Invalid operation summary bit |
| fps_ox | input | 1 | Overflow exception bit |
| bit_en | input | 1 | Single-bit write enable |
| bit_idx | input | 5 | Flat bit index |
| bit_val | input | 1 | Value written to the bit |
| cr_wr_en | input | 1 | Whole-register write enable |
| cr_wr_data | input | 32 | Whole-register write value |
| cr_rd | output | 32 | Current condition register |
| xer_wr_en | input | 1 | Exception flag write enable |
| xer_wr_data | input | 32 | Exception flag write value (32-bit view) |
| xer_rd | output | 32 | Exception flags in the 32-bit view |
| ca_a | input | 64 | Carry-detect operand a |
| ca_b | input | 64 | Carry-detect operand b |
| ca_load | input | 1 | Load carry flag from the carry detector |
| ca_out | output | 1 | Carry-detect result |

## Verification
The assertions assume that the control inputs are known (not X or Z) at every rising edge after reset. They also assume that a field-level check is meaningful only in a cycle where no whole-register write is pending, so each property excludes that case in its antecedent. The floating-point check additionally excludes a compare aimed at field 1. The stimulus drives every input at the falling edge and returns all enables to zero between operations. Deliberate same-cycle collisions are created only in the priority and full-write tests, where the bench's own model resolves the outcome from the requirements.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int FLD_W   = 4;
    localparam int LT_BIT  = 3;
    localparam int GT_BIT  = 2;
    localparam int EQ_BIT  = 1;
    localparam int SO_BIT  = 0;
    localparam int XV_W    = 32;
    localparam int XV_SO   = 31;
    localparam int XV_OV   = 30;
    localparam int XV_CA   = 29;

    typedef logic [FLD_W-1:0] crf_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xflags_t;
endpackage

// File: rtl/cr_cmp.sv
module cr_cmp
    import cr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_signed,
    input  logic            wide,
    input  logic            so_in,
    output crf_t            nib
);
    localparam int HALF = XLEN / 2;
    localparam int EW   = XLEN + 1;

    logic [EW-1:0] ax, bx;
    logic          lt, eq, gt;

    always_comb begin
        if (wide) begin
            ax = {is_signed & a[XLEN-1], a};
            bx = {is_signed & b[XLEN-1], b};
        end else begin
            ax = {{(EW-HALF){is_signed & a[HALF-1]}}, a[HALF-1:0]};
            bx = {{(EW-HALF){is_signed & b[HALF-1]}}, b[HALF-1:0]};
        end
        lt = $signed(ax) < $signed(bx);
        eq = (ax == bx);
        gt = !lt && !eq;
        nib = '0;
        nib[LT_BIT] = lt;
        nib[GT_BIT] = gt;
        nib[EQ_BIT] = eq;
        nib[SO_BIT] = so_in;
    end
endmodule

// File: rtl/cr_carry.sv
module cr_carry #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            carry
);
    assign carry = a > ~b;
endmodule

// File: rtl/cr_bitsel.sv
module cr_bitsel #(
    parameter int CR_W  = 32,
    parameter int IDX_W = $clog2(CR_W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CR_W-1:0]  onehot
);
    for (genvar g = 0; g < CR_W; g++) begin : g_dec
        assign onehot[g] = (idx == IDX_W'(CR_W - 1 - g));
    end
endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit
    import cr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int FIELDS = 8,
    localparam int CR_W   = FIELDS * FLD_W,
    localparam int IDX_W  = $clog2(CR_W),
    localparam int FSEL_W = $clog2(FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [FSEL_W-1:0] cmp_sel,
    input  logic              cmp_sgn,
    input  logic              cmp_wide,
    input  logic [XLEN-1:0]   cmp_a,
    input  logic [XLEN-1:0]   cmp_b,
    input  logic              rec_en,
    input  logic              rec_wide,
    input  logic [XLEN-1:0]   rec_val,
    input  logic              fps_en,
    input  logic              fps_fx,
    input  logic              fps_fex,
    input  logic              fps_vx,
    input  logic              fps_ox,
    input  logic              bit_en,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    input  logic              cr_wr_en,
    input  logic [CR_W-1:0]   cr_wr_data,
    output logic [CR_W-1:0]   cr_rd,
    input  logic              xer_wr_en,
    input  logic [XV_W-1:0]   xer_wr_data,
    output logic [XV_W-1:0]   xer_rd,
    input  logic [XLEN-1:0]   ca_a,
    input  logic [XLEN-1:0]   ca_b,
    input  logic              ca_load,
    output logic              ca_out
);
    typedef struct packed {
        logic [CR_W-1:0] cr;
        xflags_t         xf;
    } state_t;

    state_t st_d, st_q;

    crf_t            cmp_nib_d;
    crf_t            rec_nib_d;
    crf_t            fps_nib_d;
    logic [CR_W-1:0] bit_mask_d;
    logic            carry_d;

    cr_cmp #(.XLEN(XLEN)) u_cmp (
        .a         (cmp_a),
        .b         (cmp_b),
        .is_signed (cmp_sgn),
        .wide      (cmp_wide),
        .so_in     (st_q.xf.so),
        .nib       (cmp_nib_d)
    );

    cr_cmp #(.XLEN(XLEN)) u_rec (
        .a         (rec_val),
        .b         ('0),
        .is_signed (1'b1),
        .wide      (rec_wide),
        .so_in     (st_q.xf.so),
        .nib       (rec_nib_d)
    );

    cr_carry #(.XLEN(XLEN)) u_carry (
        .a     (ca_a),
        .b     (ca_b),
        .carry (carry_d)
    );

    cr_bitsel #(.CR_W(CR_W), .IDX_W(IDX_W)) u_bitsel (
        .idx    (bit_idx),
        .onehot (bit_mask_d)
    );

    always_comb begin
        fps_nib_d         = '0;
        fps_nib_d[LT_BIT] = fps_fx;
        fps_nib_d[GT_BIT] = fps_fex;
        fps_nib_d[EQ_BIT] = fps_vx;
        fps_nib_d[SO_BIT] = fps_ox;
    end

    always_comb begin
        st_d = st_q;
        if (cr_wr_en) begin
            st_d.cr = cr_wr_data;
        end else begin
            // lowest priority first, later writes overlay earlier ones
            if (bit_en) begin
                st_d.cr = bit_val ? (st_d.cr | bit_mask_d) : (st_d.cr & ~bit_mask_d);
            end
            if (fps_en) begin
                st_d.cr[(FIELDS-2)*FLD_W +: FLD_W] = fps_nib_d;
            end
            if (rec_en) begin
                st_d.cr[(FIELDS-1)*FLD_W +: FLD_W] = rec_nib_d;
            end
            for (int f = 0; f < FIELDS; f++) begin
                if (cmp_en && (cmp_sel == FSEL_W'(f))) begin
                    st_d.cr[(FIELDS-1-f)*FLD_W +: FLD_W] = cmp_nib_d;
                end
            end
        end
        if (xer_wr_en) begin
            st_d.xf.so = xer_wr_data[XV_SO];
            st_d.xf.ov = xer_wr_data[XV_OV];
            st_d.xf.ca = xer_wr_data[XV_CA];
        end
        if (ca_load) begin
            st_d.xf.ca = carry_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        xer_rd        = '0;
        xer_rd[XV_SO] = st_q.xf.so;
        xer_rd[XV_OV] = st_q.xf.ov;
        xer_rd[XV_CA] = st_q.xf.ca;
    end

    assign cr_rd  = st_q.cr;
    assign ca_out = carry_d;
endmodule

// File: rtl/cr_update_chk.sv
module cr_update_chk
    import cr_pkg::*;
#(
    parameter int FIELDS = 8,
    localparam int CR_W   = FIELDS * FLD_W,
    localparam int FSEL_W = $clog2(FIELDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_en,
    input logic [FSEL_W-1:0] cmp_sel,
    input logic              rec_en,
    input logic              fps_en,
    input logic              fps_fx,
    input logic              fps_fex,
    input logic              fps_vx,
    input logic              fps_ox,
    input logic              bit_en,
    input logic              cr_wr_en,
    input logic [CR_W-1:0]   cr_wr_data,
    input logic [CR_W-1:0]   cr_rd,
    input logic              xer_wr_en,
    input logic [XV_W-1:0]   xer_rd,
    input logic              ca_load,
    input logic              ca_out
);
    logic [FSEL_W-1:0] sel_prev;
    crf_t              sel_nib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_prev <= '0;
        else        sel_prev <= cmp_sel;
    end

    assign sel_nib = cr_rd[(FIELDS-1-int'(sel_prev))*FLD_W +: FLD_W];

    a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !cr_wr_en) |=> ($countones(sel_nib[LT_BIT:EQ_BIT]) == 1));

    a_r4_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !cr_wr_en) |=> (sel_nib[SO_BIT] == $past(xer_rd[XV_SO])));

    a_r7_fp_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (fps_en && !cr_wr_en && !(cmp_en && cmp_sel == FSEL_W'(1)))
        |=> (cr_rd[CR_W-5 -: FLD_W] == $past({fps_fx, fps_fex, fps_vx, fps_ox})));

    a_r10_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr_en |=> (cr_rd == $past(cr_wr_data)));

    a_r12_ca_load: assert property (@(posedge clk) disable iff (!rst_n)
        ca_load |=> (xer_rd[XV_CA] == $past(ca_out)));

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !rec_en && !fps_en && !bit_en && !cr_wr_en && !xer_wr_en && !ca_load)
        |=> ($stable(cr_rd) && $stable(xer_rd)));
endmodule

bind cr_update_unit cr_update_chk #(.FIELDS(FIELDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (cmp_en),
    .cmp_sel    (cmp_sel),
    .rec_en     (rec_en),
    .fps_en     (fps_en),
    .fps_fx     (fps_fx),
    .fps_fex    (fps_fex),
    .fps_vx     (fps_vx),
    .fps_ox     (fps_ox),
    .bit_en     (bit_en),
    .cr_wr_en   (cr_wr_en),
    .cr_wr_data (cr_wr_data),
    .cr_rd      (cr_rd),
    .xer_wr_en  (xer_wr_en),
    .xer_rd     (xer_rd),
    .ca_load    (ca_load),
    .ca_out     (ca_out)
);

// File: tb/sim_cr_update_unit.sv
module sim_cr_update_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_en = 0, cmp_sgn = 0, cmp_wide = 0;
    logic [2:0]  cmp_sel = 0;
    logic [63:0] cmp_a = 0, cmp_b = 0;
    logic        rec_en = 0, rec_wide = 0;
    logic [63:0] rec_val = 0;
    logic        fps_en = 0, fps_fx = 0, fps_fex = 0, fps_vx = 0, fps_ox = 0;
    logic        bit_en = 0, bit_val = 0;
    logic [4:0]  bit_idx = 0;
    logic        cr_wr_en = 0;
    logic [31:0] cr_wr_data = 0;
    logic        xer_wr_en = 0;
    logic [31:0] xer_wr_data = 0;
    logic [63:0] ca_a = 0, ca_b = 0;
    logic        ca_load = 0;
    logic [31:0] cr_rd, xer_rd;
    logic        ca_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_cr  = 0;
    logic [31:0] m_xer = 0;

    logic [31:0] q_cr[$];
    logic [31:0] q_xer[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_update_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .cmp_en(cmp_en), .cmp_sel(cmp_sel), .cmp_sgn(cmp_sgn), .cmp_wide(cmp_wide),
        .cmp_a(cmp_a), .cmp_b(cmp_b),
        .rec_en(rec_en), .rec_wide(rec_wide), .rec_val(rec_val),
        .fps_en(fps_en), .fps_fx(fps_fx), .fps_fex(fps_fex), .fps_vx(fps_vx), .fps_ox(fps_ox),
        .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .cr_rd(cr_rd),
        .xer_wr_en(xer_wr_en), .xer_wr_data(xer_wr_data), .xer_rd(xer_rd),
        .ca_a(ca_a), .ca_b(ca_b), .ca_load(ca_load), .ca_out(ca_out)
    );

    // independent reference compare: LT=8 GT=4 EQ=2 SO=1
    function automatic logic [3:0] ref_cmp(logic [63:0] a, logic [63:0] b,
                                           logic sg, logic wd, logic so);
        logic lt, eq;
        if (wd) begin
            lt = sg ? ($signed(a) < $signed(b)) : (a < b);
            eq = (a == b);
        end else begin
            lt = sg ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
            eq = (a[31:0] == b[31:0]);
        end
        if (eq)      return {3'b001, so};
        else if (lt) return {3'b100, so};
        else         return {3'b010, so};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // driver: inputs already set at a falling edge; build model, push, advance
    task automatic commit(string tag);
        logic       so_old;
        logic [3:0] nib;
        so_old = m_xer[31];
        if (cr_wr_en) begin
            m_cr = cr_wr_data;
        end else begin
            if (bit_en) m_cr[31 - bit_idx] = bit_val;
            if (fps_en) m_cr[27:24] = {fps_fx, fps_fex, fps_vx, fps_ox};
            if (rec_en) m_cr[31:28] = ref_cmp(rec_val, 64'd0, 1'b1, rec_wide, so_old);
            if (cmp_en) begin
                nib = ref_cmp(cmp_a, cmp_b, cmp_sgn, cmp_wide, so_old);
                m_cr[31 - 4*cmp_sel -: 4] = nib;
            end
        end
        if (xer_wr_en) m_xer = xer_wr_data & 32'hE000_0000;
        if (ca_load)   m_xer[29] = (ca_a > ~ca_b);
        q_cr.push_back(m_cr);
        q_xer.push_back(m_xer);
        q_tag.push_back(tag);
        @(negedge clk);
        cmp_en = 0; rec_en = 0; fps_en = 0; bit_en = 0;
        cr_wr_en = 0; xer_wr_en = 0; ca_load = 0;
    endtask

    // monitor: pops after each rising edge once registers have settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_cr.size() > 0) begin
                string t;
                logic [31:0] ec, ex;
                ec = q_cr.pop_front();
                ex = q_xer.pop_front();
                t  = q_tag.pop_front();
                check({t, " cr"}, cr_rd, ec);
                check({t, " xer"}, xer_rd, ex);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_cmp(string tag, logic [2:0] f, logic sg, logic wd,
                          logic [63:0] a, logic [63:0] b);
        cmp_en = 1; cmp_sel = f; cmp_sgn = sg; cmp_wide = wd; cmp_a = a; cmp_b = b;
        commit(tag);
    endtask

    task automatic do_rec(string tag, logic wd, logic [63:0] v);
        rec_en = 1; rec_wide = wd; rec_val = v;
        commit(tag);
    endtask

    task automatic do_bit(string tag, logic [4:0] i, logic v);
        bit_en = 1; bit_idx = i; bit_val = v;
        commit(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset cr", cr_rd, 32'h0);
        check("R1 reset xer", xer_rd, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R11: exception flag view, other bits ignored
        xer_wr_en = 1; xer_wr_data = 32'hFFFF_FFFF; commit("R11 xer write all");
        xer_wr_en = 1; xer_wr_data = 32'h5FFF_FFFF; commit("R11 xer write ov only");
        xer_wr_en = 1; xer_wr_data = 32'h8000_0000; commit("R11 xer write so only");

        // R2 R3 R4 R5: compares with SO=1
        do_cmp("R3 R4 signed64 lt field3", 3'd3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        do_cmp("R5 unsigned64 gt field3", 3'd3, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        do_cmp("R2 eq field7", 3'd7, 0, 1, 64'd42, 64'd42);
        do_cmp("R2 lt field0", 3'd0, 0, 1, 64'd1, 64'd2);
        do_cmp("R5 narrow eq ignores high", 3'd5, 0, 0, 64'h1_0000_0005, 64'h5);
        do_cmp("R5 wide sees high", 3'd5, 0, 1, 64'h1_0000_0005, 64'h5);
        do_cmp("R5 narrow signed lt", 3'd6, 1, 0, 64'h8000_0000, 64'd1);
        do_cmp("R5 narrow unsigned gt", 3'd6, 0, 0, 64'h8000_0000, 64'd1);

        // R4: SO cleared then compared
        xer_wr_en = 1; xer_wr_data = 32'h0; commit("R11 xer clear");
        do_cmp("R4 so zero copy", 3'd2, 1, 1, 64'd9, 64'd3);

        // R6: record form
        do_rec("R6 zero eq", 1, 64'd0);
        do_rec("R6 negative lt", 1, 64'hFFFF_FFFF_FFFF_FFF0);
        do_rec("R6 narrow sign lt", 0, 64'h0000_0000_8000_0000);
        do_rec("R6 wide positive gt", 1, 64'h0000_0000_8000_0000);

        // R7: floating-point summary
        fps_en = 1; {fps_fx, fps_fex, fps_vx, fps_ox} = 4'b1010; commit("R7 fps 1010");
        fps_en = 1; {fps_fx, fps_fex, fps_vx, fps_ox} = 4'b0101; commit("R7 fps 0101");

        // R8: single bits
        do_bit("R8 set bit0", 5'd0, 1);
        do_bit("R8 set bit31", 5'd31, 1);
        do_bit("R8 clear bit13", 5'd13, 0);
        do_bit("R8 set bit13", 5'd13, 1);

        // R9: priorities
        cmp_en = 1; cmp_sel = 3'd3; cmp_sgn = 0; cmp_wide = 1; cmp_a = 5; cmp_b = 5;
        bit_en = 1; bit_idx = 5'd12; bit_val = 1;
        commit("R9 compare over bit same field");
        cmp_en = 1; cmp_sel = 3'd4; cmp_sgn = 0; cmp_wide = 1; cmp_a = 1; cmp_b = 5;
        bit_en = 1; bit_idx = 5'd1; bit_val = 0;
        commit("R9 compare and bit different fields");
        cmp_en = 1; cmp_sel = 3'd0; cmp_a = 7; cmp_b = 3;
        rec_en = 1; rec_wide = 1; rec_val = 0;
        commit("R9 compare over record");
        fps_en = 1; {fps_fx, fps_fex, fps_vx, fps_ox} = 4'b1111;
        cmp_en = 1; cmp_sel = 3'd1; cmp_a = 0; cmp_b = 0;
        commit("R9 compare over fps");

        // R10: full write discards others
        cr_wr_en = 1; cr_wr_data = 32'hA5C3_0F96;
        cmp_en = 1; cmp_sel = 3'd2; bit_en = 1; bit_idx = 5'd30; bit_val = 1;
        commit("R10 full write wins");

        // R12: carry detect
        ca_a = 64'd1; ca_b = 64'hFFFF_FFFF_FFFF_FFFF; #1;
        check("R12 carry one", {31'd0, ca_out}, 32'd1);
        ca_a = 64'd0; #1;
        check("R12 carry zero", {31'd0, ca_out}, 32'd0);
        ca_a = 64'h8000_0000_0000_0000; ca_b = 64'h8000_0000_0000_0000; ca_load = 1;
        xer_wr_en = 1; xer_wr_data = 32'h4000_0000;
        commit("R12 ca load over xer write");
        ca_a = 64'd3; ca_b = 64'd4; ca_load = 1; commit("R12 ca load zero");

        // R13: idle hold
        commit("R13 idle");
        commit("R13 idle again");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule